// File: doc/BRIEF.md
# Access-Driven SIMD Microkernel Sequencer

This block is a near-memory compute unit that holds a short stored program and advances it by exactly one instruction for each memory command it accepts. It never runs on its own: the host issues reads and writes in an order matching the stored program. Each command supplies a 256-bit burst, which the current instruction may use as an operand. It also supplies a row and a column index, which may select vector registers. The unit contains a 32-word program store, two banks of eight 256-bit vector registers (bank A for inputs, bank B for accumulators), and two banks of eight 16-bit scalars. One scalar bank feeds additions and the other feeds multiplications, and each scalar is copied into all sixteen lanes when it is read. Arithmetic is 16-bit integer, lane by lane, wrapping modulo 2^16.

A typical use is matrix-vector multiply. Input chunks are filled into bank A. Multiply-accumulate steps then combine bank A with matrix rows arriving on the bus and collect the partial products lane-wise in bank B. Finally the bank B entries are moved out as results. The host adds the sixteen lanes of each result itself. A three-value mode input selects program loading (single-bank), passive operation (all-bank) or execution (all-bank-processing).

The command port is a valid/ready stream. A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. Results leave on a valid/ready stream as well. `cmd_ready` is low only while a result is pending and `res_ready` is low, so a result is never overwritten. While `res_ready` is low, the pending result holds its value.

Top module: `mk_seq_top`

## Requirements
- R1: After reset the program counter is 0 and all vector and scalar registers are zero. `done`, `res_valid` and `res_to_bank` are 0, and `cmd_ready` is 1.
- R2: `pl_en` writes `pl_word` into program slot `pl_addr` only while `mode` is single-bank (0). In any other mode it has no effect.
- R3: Mode encodings are: single-bank 0, all-bank 1, execution 2. A command taken while `mode` is not 2 changes no state and produces no result. When `mode` becomes 2, the next cycle resets the program counter to 0 and clears `done` and every loop counter. Commands execute from the cycle after that entry.
- R4: Instruction word layout:
  - opcode in [31:28], with NOP=0, JUMP=1, EXIT=2, ADD=3, MUL=4, MAC=5, MAD=6, MOV=7, FILL=8;
  - address-index flag in [27];
  - destination type in [26:24], first-source type in [23:21], second-source type in [20:18];
  - destination index in [10:8], first-source index in [6:4], second-source index in [2:0];
  - JUMP takes its loop count from [17:11] and its target from [4:0].
- R5: Operand type codes are: none 0, vector bank A 1, vector bank B 2, add-scalar 3, multiply-scalar 4, bus 5. A scalar operand appears in all 16 lanes. A bus source is the command's `cmd_data`.
- R6: ADD gives s0+s1 and MUL gives s0*s1, per 16-bit lane, modulo 2^16. MAD gives s0*M+A, where M and A are the multiply-scalar and add-scalar entries at the second-source index; the second-source type is ignored.
- R7: MAC gives dst + s0*s1 per lane, using the destination's current value, with no sum across lanes.
- R8: When the address-index flag is set, every bank A operand uses `cmd_col` as its index and every bank B operand uses `cmd_row`. Scalar indices still come from the instruction word.
- R9: MOV copies s0 to the destination and FILL copies `cmd_data` to the destination. A scalar destination keeps lane 0 (bits 15:0). Instructions that use no bus operand ignore `cmd_data`.
- R10: JUMP uses one loop counter per program slot. If that counter is below the loop count, the counter increments and the program counter goes to the target. Otherwise the counter clears and execution falls through. The loop body therefore runs count+1 times.
- R11: EXIT sets `done` one cycle after it is taken. While `done` is set, commands are taken but do nothing. `done` clears once `mode` is not 2.
- R12: An instruction whose destination type is bus raises `res_valid` in the cycle after the command, carrying the result on `res_data`. `res_to_bank` is 1 for a write command and 0 for a read.
- R13: `cmd_ready` equals `!res_valid || res_ready`. While `res_valid` is high and `res_ready` is low, `res_valid` and `res_data` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 0 single-bank, 1 all-bank, 2 execution |
| pl_en | input | 1 | Program word write strobe |
| pl_addr | input | 5 | Program slot to write |
| pl_word | input | 32 | Instruction word to store |
| cmd_valid | input | 1 | Memory command present |
| cmd_ready | output | 1 | Command can be taken |
| cmd_write | input | 1 | 1 for write command, 0 for read |
| cmd_row | input | 3 | Low row address bits of the command |
| cmd_col | input | 3 | Low column address bits of the command |
| cmd_data | input | 256 | Burst data carried by the command |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Result consumer accepts |
| res_data | output | 256 | Result vector |
| res_to_bank | output | 1 | Result belongs to a write (1) or a read (0) |
| done | output | 1 | Program reached EXIT |

## Verification
The hardest condition to reach from the ports is a nested loop whose register selection follows the address. Every command must carry the row and column that match the position of the loop. Otherwise multiply-accumulate results land in the wrong accumulator, and the error shows only after the final move-out. The stimulus therefore builds the access stream from the kernel's own loop nest and fills it with random matrix and vector data. JUMP commands carry random bus data to show that it is ignored. A second entry into execution mode without reset must double every accumulator, which exercises restart and the clearing of the loop counters together. A directed run holds `res_ready` low after a result to force the stall.

// File: rtl/mk_pkg.sv
package mk_pkg;
  localparam int INSTR_W = 32;
  localparam int DEPTH   = 32;
  localparam int PC_W    = $clog2(DEPTH);
  localparam int HALF    = 8;
  localparam int IDX_W   = $clog2(HALF);
  localparam int CNT_W   = 7;

  typedef enum logic [3:0] {
    OP_NOP = 4'd0, OP_JUMP = 4'd1, OP_EXIT = 4'd2, OP_ADD = 4'd3, OP_MUL = 4'd4,
    OP_MAC = 4'd5, OP_MAD = 4'd6, OP_MOV = 4'd7, OP_FILL = 4'd8
  } op_e;

  typedef enum logic [2:0] {
    OT_NONE = 3'd0, OT_GA = 3'd1, OT_GB = 3'd2, OT_SA = 3'd3, OT_SM = 3'd4, OT_BUS = 3'd5
  } ot_e;

  localparam logic [1:0] MD_SB  = 2'd0;
  localparam logic [1:0] MD_AB  = 2'd1;
  localparam logic [1:0] MD_ABP = 2'd2;
endpackage

// File: rtl/mk_cmd_store.sv
module mk_cmd_store #(
  parameter int DEPTH  = 32,
  parameter int WORD_W = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/mk_lane_alu.sv
module mk_lane_alu import mk_pkg::*; #(
  parameter int LANES  = 16,
  parameter int LANE_W = 16,
  localparam int VEC_W = LANES * LANE_W
) (
  input  op_e              op,
  input  logic [VEC_W-1:0] a,
  input  logic [VEC_W-1:0] b,
  input  logic [VEC_W-1:0] c,
  output logic [VEC_W-1:0] y
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] al, bl, cl, prod, yl;
    assign al   = a[l*LANE_W +: LANE_W];
    assign bl   = b[l*LANE_W +: LANE_W];
    assign cl   = c[l*LANE_W +: LANE_W];
    assign prod = al * bl;
    always_comb begin
      case (op)
        OP_ADD:         yl = al + bl;
        OP_MUL:         yl = prod;
        OP_MAC, OP_MAD: yl = prod + cl;
        default:        yl = al;
      endcase
    end
    assign y[l*LANE_W +: LANE_W] = yl;
  end
endmodule

// File: rtl/mk_seq_top.sv
module mk_seq_top import mk_pkg::*; #(
  parameter int LANES  = 16,
  parameter int LANE_W = 16,
  localparam int VEC_W = LANES * LANE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         mode,
  input  logic               pl_en,
  input  logic [PC_W-1:0]    pl_addr,
  input  logic [INSTR_W-1:0] pl_word,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic               cmd_write,
  input  logic [IDX_W-1:0]   cmd_row,
  input  logic [IDX_W-1:0]   cmd_col,
  input  logic [VEC_W-1:0]   cmd_data,
  output logic               res_valid,
  input  logic               res_ready,
  output logic [VEC_W-1:0]   res_data,
  output logic               res_to_bank,
  output logic               done
);
  logic [VEC_W-1:0]  grf_a [HALF];
  logic [VEC_W-1:0]  grf_b [HALF];
  logic [LANE_W-1:0] srf_a [HALF];
  logic [LANE_W-1:0] srf_m [HALF];
  logic [CNT_W-1:0]  lcnt  [DEPTH];
  logic [PC_W-1:0]   pc;
  logic              in_abp_q;
  logic [INSTR_W-1:0] ir;

  mk_cmd_store #(.DEPTH(DEPTH), .WORD_W(INSTR_W)) u_store (
    .clk(clk), .we(pl_en && mode == MD_SB), .waddr(pl_addr), .wdata(pl_word),
    .raddr(pc), .rdata(ir)
  );

  // instruction fields
  op_e op;
  ot_e dt, s0t, s1t;
  logic aam;
  logic [IDX_W-1:0] f_d, f_s0, f_s1;
  logic [CNT_W-1:0] jcnt;
  logic [PC_W-1:0]  jtgt;
  logic unused_rsvd;
  assign op   = op_e'(ir[31:28]);
  assign aam  = ir[27];
  assign dt   = ot_e'(ir[26:24]);
  assign s0t  = ot_e'(ir[23:21]);
  assign s1t  = ot_e'(ir[20:18]);
  assign jcnt = ir[17:11];
  assign f_d  = ir[10:8];
  assign f_s0 = ir[6:4];
  assign f_s1 = ir[2:0];
  assign jtgt = ir[4:0];
  assign unused_rsvd = ^{ir[7], ir[3]};

  // address-aligned index selection
  logic [IDX_W-1:0] ia_d, ib_d, ia_0, ib_0, ia_1, ib_1;
  assign ia_d = aam ? cmd_col : f_d;
  assign ib_d = aam ? cmd_row : f_d;
  assign ia_0 = aam ? cmd_col : f_s0;
  assign ib_0 = aam ? cmd_row : f_s0;
  assign ia_1 = aam ? cmd_col : f_s1;
  assign ib_1 = aam ? cmd_row : f_s1;

  logic [VEC_W-1:0] s0v, s1v, dcur, alu_a, alu_b, alu_c, alu_y;
  always_comb begin
    case (s0t)
      OT_GA:   s0v = grf_a[ia_0];
      OT_GB:   s0v = grf_b[ib_0];
      OT_SA:   s0v = {LANES{srf_a[f_s0]}};
      OT_SM:   s0v = {LANES{srf_m[f_s0]}};
      OT_BUS:  s0v = cmd_data;
      default: s0v = '0;
    endcase
    case (s1t)
      OT_GA:   s1v = grf_a[ia_1];
      OT_GB:   s1v = grf_b[ib_1];
      OT_SA:   s1v = {LANES{srf_a[f_s1]}};
      OT_SM:   s1v = {LANES{srf_m[f_s1]}};
      OT_BUS:  s1v = cmd_data;
      default: s1v = '0;
    endcase
    case (dt)
      OT_GA:   dcur = grf_a[ia_d];
      OT_GB:   dcur = grf_b[ib_d];
      OT_SA:   dcur = {LANES{srf_a[f_d]}};
      OT_SM:   dcur = {LANES{srf_m[f_d]}};
      default: dcur = '0;
    endcase
  end

  assign alu_a = (op == OP_FILL) ? cmd_data : s0v;
  assign alu_b = (op == OP_MAD) ? {LANES{srf_m[f_s1]}} : s1v;
  assign alu_c = (op == OP_MAD) ? {LANES{srf_a[f_s1]}} : dcur;

  mk_lane_alu #(.LANES(LANES), .LANE_W(LANE_W)) u_alu (
    .op(op), .a(alu_a), .b(alu_b), .c(alu_c), .y(alu_y)
  );

  logic is_abp, entry, exec, data_op;
  assign is_abp    = (mode == MD_ABP);
  assign entry     = is_abp && !in_abp_q;
  assign cmd_ready = !res_valid || res_ready;
  assign exec      = cmd_valid && cmd_ready && is_abp && in_abp_q && !done;
  assign data_op   = (op == OP_ADD) || (op == OP_MUL) || (op == OP_MAC) ||
                     (op == OP_MAD) || (op == OP_MOV) || (op == OP_FILL);

  // register files
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < HALF; i++) begin
        grf_a[i] <= '0;
        grf_b[i] <= '0;
        srf_a[i] <= '0;
        srf_m[i] <= '0;
      end
    end else if (exec && data_op) begin
      case (dt)
        OT_GA:   grf_a[ia_d] <= alu_y;
        OT_GB:   grf_b[ib_d] <= alu_y;
        OT_SA:   srf_a[f_d]  <= alu_y[LANE_W-1:0];
        OT_SM:   srf_m[f_d]  <= alu_y[LANE_W-1:0];
        default: ;
      endcase
    end
  end

  // sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc       <= '0;
      done     <= 1'b0;
      in_abp_q <= 1'b0;
      for (int i = 0; i < DEPTH; i++) lcnt[i] <= '0;
    end else begin
      in_abp_q <= is_abp;
      if (!is_abp) done <= 1'b0;
      if (entry) begin
        pc   <= '0;
        done <= 1'b0;
        for (int i = 0; i < DEPTH; i++) lcnt[i] <= '0;
      end else if (exec) begin
        case (op)
          OP_JUMP: begin
            if (lcnt[pc] < jcnt) begin
              lcnt[pc] <= lcnt[pc] + 1'b1;
              pc       <= jtgt;
            end else begin
              lcnt[pc] <= '0;
              pc       <= pc + 1'b1;
            end
          end
          OP_EXIT: done <= 1'b1;
          default: pc <= pc + 1'b1;
        endcase
      end
    end
  end

  // result stream
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_data    <= '0;
      res_to_bank <= 1'b0;
    end else begin
      if (res_valid && res_ready) res_valid <= 1'b0;
      if (exec && data_op && dt == OT_BUS) begin
        res_valid   <= 1'b1;
        res_data    <= alu_y;
        res_to_bank <= cmd_write;
      end
    end
  end

  logic jump_fall;
  assign jump_fall = exec && op == OP_JUMP && !(lcnt[pc] < jcnt);

  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data))); // R13
  AST_ENTRY_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    entry |=> (pc == '0 && !done)); // R3
  AST_IDLE_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_abp && !res_valid) |=> !res_valid); // R3
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && is_abp && in_abp_q) |=> $stable(pc)); // R11
  AST_JUMP_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    jump_fall |=> (pc == $past(pc) + 1'b1)); // R10
endmodule

// File: tb/tb_mk_seq_top.sv
`timescale 1ns/1ps
module tb_mk_seq_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic pl_en = 1'b0;
  logic [4:0] pl_addr = '0;
  logic [31:0] pl_word = '0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic cmd_write = 1'b0;
  logic [2:0] cmd_row = '0, cmd_col = '0;
  logic [255:0] cmd_data = '0;
  logic res_valid, res_to_bank, done;
  logic res_ready = 1'b1;
  logic [255:0] res_data;

  int checks = 0, fails = 0;
  logic got_v, got_b;
  logic [255:0] got_d;
  logic [255:0] av [4];
  logic [255:0] wm [4][4];
  logic [255:0] ex [4];

  always #2 clk = ~clk;

  mk_seq_top dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .pl_en(pl_en), .pl_addr(pl_addr),
    .pl_word(pl_word), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_row(cmd_row), .cmd_col(cmd_col),
    .cmd_data(cmd_data), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .res_to_bank(res_to_bank), .done(done)
  );

  function automatic logic [255:0] vadd(input logic [255:0] a, input logic [255:0] b);
    logic [255:0] r;
    for (int l = 0; l < 16; l++) r[l*16 +: 16] = a[l*16 +: 16] + b[l*16 +: 16];
    return r;
  endfunction
  function automatic logic [255:0] vmul(input logic [255:0] a, input logic [255:0] b);
    logic [255:0] r;
    for (int l = 0; l < 16; l++) r[l*16 +: 16] = a[l*16 +: 16] * b[l*16 +: 16];
    return r;
  endfunction
  function automatic logic [255:0] bc(input logic [15:0] s);
    return {16{s}};
  endfunction
  function automatic logic [255:0] rvec();
    logic [255:0] r;
    for (int i = 0; i < 8; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction
  function automatic logic [31:0] ins(input logic [3:0] op, input logic aam,
      input logic [2:0] dt, input logic [2:0] s0t, input logic [2:0] s1t,
      input logic [2:0] di, input logic [2:0] s0i, input logic [2:0] s1i);
    return {op, aam, dt, s0t, s1t, 7'd0, di, 1'b0, s0i, 1'b0, s1i};
  endfunction
  function automatic logic [31:0] jmp(input logic [4:0] tgt, input logic [6:0] cnt);
    return {4'd1, 1'b0, 9'd0, cnt, 6'd0, tgt};
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [4:0] a, input logic [31:0] w);
    pl_en = 1'b1; pl_addr = a; pl_word = w;
    @(negedge clk);
    pl_en = 1'b0;
  endtask

  task automatic issue(input logic wr, input logic [2:0] r, input logic [2:0] c, input logic [255:0] d);
    cmd_valid = 1'b1; cmd_write = wr; cmd_row = r; cmd_col = c; cmd_data = d;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    got_v = res_valid; got_d = res_data; got_b = res_to_bank;
  endtask

  task automatic enter_exec();
    mode = 2'd2;
    @(negedge clk);
  endtask

  task automatic gemv_pass(input int times);
    for (int c = 0; c < 4; c++) begin
      issue(1'b1, 3'd0, c[2:0], av[c]);
      issue(1'b0, 3'd0, 3'd0, rvec());
    end
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) begin
        issue(1'b0, r[2:0], c[2:0], wm[r][c]);
        issue(1'b0, 3'd0, 3'd0, rvec());
      end
    for (int r = 0; r < 4; r++) begin
      issue(1'b0, r[2:0], 3'd5, rvec());
      chk(got_v && got_d == (times == 2 ? vadd(ex[r], ex[r]) : ex[r]),
          "R7/R8 accumulator row result", got_d, ex[r]);
      chk(got_b == 1'b0, "R12 read routes to host", {255'd0, got_b}, 256'd0);
      issue(1'b0, 3'd0, 3'd0, rvec());
    end
    issue(1'b0, 3'd0, 3'd0, rvec());
    chk(done == 1'b1, "R11 done after exit", {255'd0, done}, 256'd1);
    issue(1'b1, 3'd1, 3'd1, rvec());
    chk(!got_v && done, "R11 access after exit ignored", {255'd0, got_v}, 256'd0);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [255:0] dsa, dsm, v, dmv, e;
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !res_valid && cmd_ready && !res_to_bank, "R1 reset outputs",
        {252'd0, done, res_valid, cmd_ready, res_to_bank}, 256'd2);

    // matrix-vector kernel with random data
    for (int t = 0; t < 3; t++) begin
      rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; mode = 2'd0; @(negedge clk);
      load(5'd0, ins(4'd8, 1'b1, 3'd1, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0));
      load(5'd1, jmp(5'd0, 7'd3));
      load(5'd2, ins(4'd5, 1'b1, 3'd2, 3'd1, 3'd5, 3'd0, 3'd0, 3'd0));
      load(5'd3, jmp(5'd2, 7'd15));
      load(5'd4, ins(4'd7, 1'b1, 3'd5, 3'd2, 3'd0, 3'd0, 3'd0, 3'd0));
      load(5'd5, jmp(5'd4, 7'd3));
      load(5'd6, ins(4'd2, 1'b0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0));
      for (int i = 0; i < 4; i++) begin
        av[i] = (t == 0 && i == 0) ? {256{1'b1}} : rvec();
        for (int j = 0; j < 4; j++) wm[i][j] = rvec();
      end
      for (int r = 0; r < 4; r++) begin
        e = '0;
        for (int c = 0; c < 4; c++) e = vadd(e, vmul(av[c], wm[r][c]));
        ex[r] = e;
      end
      enter_exec();
      gemv_pass(1);
      mode = 2'd0; @(negedge clk);
      chk(!done, "R11 done clears on leaving exec", {255'd0, done}, 256'd0);
      enter_exec();
      gemv_pass(2);   // R3 restart from slot 0, R10 counters cleared
      mode = 2'd0; @(negedge clk);
    end

    // scalar / move program
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
    load(5'd0, ins(4'd7, 1'b0, 3'd3, 3'd5, 3'd0, 3'd2, 3'd0, 3'd0));
    load(5'd1, ins(4'd7, 1'b0, 3'd4, 3'd5, 3'd0, 3'd2, 3'd0, 3'd0));
    load(5'd2, ins(4'd8, 1'b0, 3'd1, 3'd0, 3'd0, 3'd1, 3'd0, 3'd0));
    load(5'd3, ins(4'd3, 1'b0, 3'd5, 3'd1, 3'd3, 3'd0, 3'd1, 3'd2));
    load(5'd4, ins(4'd4, 1'b0, 3'd5, 3'd1, 3'd4, 3'd0, 3'd1, 3'd2));
    load(5'd5, ins(4'd6, 1'b0, 3'd5, 3'd1, 3'd0, 3'd0, 3'd1, 3'd2));
    load(5'd6, ins(4'd7, 1'b0, 3'd2, 3'd5, 3'd0, 3'd5, 3'd0, 3'd0));
    load(5'd7, ins(4'd7, 1'b0, 3'd5, 3'd2, 3'd0, 3'd0, 3'd5, 3'd0));
    load(5'd8, ins(4'd2, 1'b0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0));
    for (int k = 0; k < 4; k++) begin
      mode = 2'd1; @(negedge clk);
      load(5'd3, 32'd0);                       // R2 must be ignored
      issue(1'b1, 3'd0, 3'd0, rvec());
      chk(!got_v, "R3 access outside exec ignored", {255'd0, got_v}, 256'd0);
      enter_exec();
      dsa = rvec(); dsm = (k == 0) ? {256{1'b1}} : rvec(); v = rvec(); dmv = rvec();
      issue(1'b1, $urandom_range(7), $urandom_range(7), dsa);
      issue(1'b1, $urandom_range(7), $urandom_range(7), dsm);
      issue(1'b1, $urandom_range(7), $urandom_range(7), v);
      if (k == 0) res_ready = 1'b0;
      issue(1'b1, $urandom_range(7), $urandom_range(7), rvec());
      e = vadd(v, bc(dsa[15:0]));
      chk(got_v && got_d == e, "R2/R5/R6 add with scalar broadcast", got_d, e);
      chk(got_b == 1'b1, "R12 write routes to bank", {255'd0, got_b}, 256'd1);
      if (k == 0) begin
        chk(!cmd_ready, "R13 command stalled on pending result", {255'd0, cmd_ready}, 256'd0);
        @(negedge clk);
        chk(res_valid && res_data == e, "R13 pending result held", res_data, e);
        res_ready = 1'b1;
        @(negedge clk);
      end
      issue(1'b0, $urandom_range(7), $urandom_range(7), rvec());
      e = vmul(v, bc(dsm[15:0]));
      chk(got_v && got_d == e, "R6 multiply by scalar", got_d, e);
      issue(1'b0, $urandom_range(7), $urandom_range(7), rvec());
      e = vadd(vmul(v, bc(dsm[15:0])), bc(dsa[15:0]));
      chk(got_v && got_d == e, "R6 multiply-add scalar pair", got_d, e);
      issue(1'b1, $urandom_range(7), $urandom_range(7), dmv);
      chk(!got_v, "R9 move into register gives no result", {255'd0, got_v}, 256'd0);
      issue(1'b0, $urandom_range(7), $urandom_range(7), rvec());
      chk(got_v && got_d == dmv, "R4/R9 move from bank B field index", got_d, dmv);
      issue(1'b0, 3'd0, 3'd0, rvec());
      chk(done, "R11 done after exit", {255'd0, done}, 256'd1);
      mode = 2'd0; @(negedge clk);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule